// File: doc/BRIEF.md
# Receive Flow-Control Trigger

This block decides when a MAC's receive path should throttle the far end of the link. It compares the receive FIFO fill level with a programmable threshold. It watches per-frame strobes that say whether a frame is multicast, broadcast, addressed to this station, or only that a valid preamble has started. From these and a control byte it issues one of two requests. In half duplex it raises a timed backpressure (jam) request. In full duplex it raises a single-cycle request for the transmitter to send a pause frame.

The control byte holds four trigger enables and a duration code. The duration code selects a backpressure length from a fixed table. At 10 Mb/s every entry of that table is 2.2 µs longer than at 100 Mb/s. Lengths are converted to clock cycles from the `CLK_MHZ` parameter, rounding down. The block has no data stream and no valid/ready interface. All of its pins are plain levels or single-cycle strobes.

Top module: `rx_flow_trigger`

## Requirements
- R1: While reset is held and on the first cycle after it, `bp_req` and `pause_req` are 0.
- R2: In half duplex, with the threshold reached, a multicast strobe with `ctrl[3]` set starts backpressure. A broadcast strobe with `ctrl[2]` set does the same, and so does an address-hit strobe with `ctrl[1]` set. A strobe whose enable bit is clear starts nothing. `bp_req` goes high in the cycle after the strobe's clock edge.
- R3: The threshold counts as reached when `fifo_level >= fifo_thresh`. Below it, no strobe starts backpressure and no pause is requested.
- R4: With `ctrl[0]` set in half duplex, a `preamble_ok` strobe starts backpressure and the frame-type strobes are ignored. Without `ctrl[0]`, `preamble_ok` starts nothing.
- R5: In full duplex, `bp_req` stays 0. Bits `ctrl[3:1]` alone never cause a pause request.
- R6: In full duplex with `ctrl[0]` set, reaching the threshold makes `pause_req` high for exactly one cycle, one clock after the condition is seen. Half duplex never raises `pause_req`.
- R7: After a pause request, no further request is made until `fifo_level` has fallen below `fifo_thresh` for at least one clock edge and then reached it again.
- R8: At 100 Mb/s (`speed_100`=1), codes 0 to 7 in `ctrl[6:4]` give backpressure lengths of 5, 10, 15, 25, 50, 100, 150 and 200 µs. Each length is counted as that many µs times `CLK_MHZ` cycles of `bp_req` high.
- R9: At 10 Mb/s (`speed_100`=0), each length is 2.2 µs longer: 7.2, 12.2, 17.2, 27.2, 52.2, 102.2, 152.2 and 202.2 µs.
- R10: A code with `ctrl[7]` set (8h to Fh) gives the same length as code 7.
- R11: A trigger that arrives while backpressure is active neither restarts nor extends it.
- R12: Entering full duplex, or clearing all four enable bits `ctrl[3:0]`, drops `bp_req` in the same cycle. The remaining time is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_level | input | LVL_W | Receive FIFO fill level |
| fifo_thresh | input | LVL_W | Flow-control threshold |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| ctrl | input | 8 | [0] any frame, [1] address hit, [2] broadcast, [3] multicast, [7:4] duration code |
| frm_mcast | input | 1 | One-cycle strobe: multicast frame received |
| frm_bcast | input | 1 | One-cycle strobe: broadcast frame received |
| frm_addr_hit | input | 1 | One-cycle strobe: frame addressed to this station |
| preamble_ok | input | 1 | One-cycle strobe: valid preamble seen |
| bp_req | output | 1 | Half-duplex backpressure (jam) request |
| pause_req | output | 1 | One-cycle full-duplex pause-frame request |

## Verification
The hardest state to reach is a second trigger that lands while backpressure is already active. The same is true of a mode change partway through a long hold. Both need the counter to be mid-count when the second event comes. The bench starts a short hold and waits a fixed number of cycles with `bp_req` high before it pulses a second strobe. It then checks that the total high time still equals a single length. For the mid-count drop, it starts the longest hold and then flips `full_duplex` or clears the enables. It checks that `bp_req` falls in that cycle and stays low once half duplex returns. For the pause re-arm, it holds the level above threshold for several cycles before dropping it and raising it again.

// File: rtl/rft_pkg.sv
package rft_pkg;

  localparam int CTRL_W  = 8;
  localparam int N_CODES = 8;
  localparam int SLOW_EXTRA_TENTHS = 22;

  typedef struct packed {
    logic [3:0] dur_code;
    logic       en_mcast;
    logic       en_bcast;
    logic       en_addr;
    logic       en_any;
  } rft_ctrl_t;

  function automatic int fast_tenths_us(input int code);
    case (code)
      0:       return 50;
      1:       return 100;
      2:       return 150;
      3:       return 250;
      4:       return 500;
      5:       return 1000;
      6:       return 1500;
      default: return 2000;
    endcase
  endfunction

  function automatic int max_cycles(input int clk_mhz);
    return ((fast_tenths_us(7) + SLOW_EXTRA_TENTHS) * clk_mhz) / 10;
  endfunction

endpackage

// File: rtl/rft_dur_decode.sv
module rft_dur_decode #(
  parameter int CLK_MHZ = 200,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       code,
  input  logic             speed_100,
  output logic [CNT_W-1:0] dur_cycles
);
  import rft_pkg::*;

  logic [CNT_W-1:0] cyc_fast [N_CODES];
  logic [CNT_W-1:0] cyc_slow [N_CODES];
  logic [2:0]       sel;

  for (genvar g = 0; g < N_CODES; g++) begin : g_tab
    localparam int FAST = (fast_tenths_us(g) * CLK_MHZ) / 10;
    localparam int SLOW = ((fast_tenths_us(g) + SLOW_EXTRA_TENTHS) * CLK_MHZ) / 10;
    assign cyc_fast[g] = CNT_W'(FAST);
    assign cyc_slow[g] = CNT_W'(SLOW);
  end

  // codes 8h..Fh saturate to the longest entry
  assign sel        = code[3] ? 3'd7 : code[2:0];
  assign dur_cycles = speed_100 ? cyc_fast[sel] : cyc_slow[sel];

  AST_DUR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dur_cycles != '0);  // R8
  AST_SLOW_NOT_SHORTER: assert property (@(posedge clk) disable iff (!rst_n)
    !speed_100 |-> dur_cycles >= cyc_fast[sel]);  // R9
endmodule

// File: rtl/rft_level_watch.sv
module rft_level_watch #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] fifo_thresh,
  input  logic             full_duplex,
  input  logic             en_any,
  output logic             at_thr,
  output logic             pause_req
);
  logic armed_q;
  logic pause_q;
  logic fire;

  assign at_thr = fifo_level >= fifo_thresh;
  assign fire   = full_duplex && en_any && at_thr && armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      pause_q <= 1'b0;
    end else begin
      pause_q <= fire;
      if (!at_thr)   armed_q <= 1'b1;
      else if (fire) armed_q <= 1'b0;
    end
  end

  assign pause_req = pause_q;

  AST_PAUSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |=> !pause_req);  // R7
  AST_PAUSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> $past(full_duplex && en_any && at_thr));  // R6
endmodule

// File: rtl/rft_bp_timer.sv
module rft_bp_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             kill,
  input  logic [CNT_W-1:0] dur_in,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;
  logic             idle;

  assign idle = cnt_q == '0;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (kill)         cnt_q <= '0;
    else if (!idle)        cnt_q <= cnt_q - 1'b1;
    else if (start)        cnt_q <= dur_in;
  end

  // kill masks the request combinationally so a mode change acts at once
  assign busy = !idle && !kill;

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !kill) |=> cnt_q == $past(cnt_q) - 1'b1);  // R11
  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> idle);  // R12
  AST_LOAD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && !kill) |=> cnt_q == $past(dur_in));  // R8
endmodule

// File: rtl/rx_flow_trigger.sv
module rx_flow_trigger #(
  parameter int CLK_MHZ = 200,
  parameter int LVL_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] fifo_thresh,
  input  logic             full_duplex,
  input  logic             speed_100,
  input  logic [7:0]       ctrl,
  input  logic             frm_mcast,
  input  logic             frm_bcast,
  input  logic             frm_addr_hit,
  input  logic             preamble_ok,
  output logic             bp_req,
  output logic             pause_req
);
  import rft_pkg::*;

  localparam int MAX_CYC = max_cycles(CLK_MHZ);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  rft_ctrl_t        cfg;
  logic             at_thr;
  logic             typed_hit;
  logic             hd_trig;
  logic             kill;
  logic [CNT_W-1:0] dur_cycles;

  assign cfg = rft_ctrl_t'(ctrl);

  // any-frame enable overrides the per-type enables and needs only a preamble
  assign typed_hit = (cfg.en_mcast && frm_mcast) ||
                     (cfg.en_bcast && frm_bcast) ||
                     (cfg.en_addr  && frm_addr_hit);
  assign hd_trig   = !full_duplex && at_thr &&
                     (cfg.en_any ? preamble_ok : typed_hit);
  assign kill      = full_duplex ||
                     !(cfg.en_any || cfg.en_addr || cfg.en_bcast || cfg.en_mcast);

  rft_level_watch #(.LVL_W(LVL_W)) u_level (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_level  (fifo_level),
    .fifo_thresh (fifo_thresh),
    .full_duplex (full_duplex),
    .en_any      (cfg.en_any),
    .at_thr      (at_thr),
    .pause_req   (pause_req)
  );

  rft_dur_decode #(.CLK_MHZ(CLK_MHZ), .CNT_W(CNT_W)) u_dur (
    .clk        (clk),
    .rst_n      (rst_n),
    .code       (cfg.dur_code),
    .speed_100  (speed_100),
    .dur_cycles (dur_cycles)
  );

  rft_bp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (hd_trig),
    .kill   (kill),
    .dur_in (dur_cycles),
    .busy   (bp_req)
  );

  AST_BP_HALF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req |-> !full_duplex);  // R5
  AST_PAUSE_NOT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> $past(full_duplex));  // R6
  AST_BP_START_NEEDS_THR: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bp_req) && !$past(kill)) |-> $past(at_thr));  // R3
endmodule

// File: tb/rx_flow_trigger_tb.sv
module rx_flow_trigger_tb;
  // scaled time base: durations are computed for CLK_MHZ = 10
  localparam int CLK_MHZ = 10;
  localparam int NV = 18;
  // {fd, spd100, above, ctrl[7:0], kind[1:0](0 mc,1 bc,2 addr,3 pre), exp[11:0]}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0,1'b1,1'b1,8'h08,2'd0,12'd50},    // R2 R8 mcast code0 fast
    {1'b0,1'b0,1'b1,8'h34,2'd1,12'd272},   // R2 R9 bcast code3 slow
    {1'b0,1'b1,1'b1,8'h72,2'd2,12'd2000},  // R2 R8 addr code7 fast
    {1'b0,1'b0,1'b1,8'hF8,2'd0,12'd2022},  // R10 R9 code F slow
    {1'b0,1'b1,1'b1,8'h92,2'd2,12'd2000},  // R10 code 9 fast
    {1'b0,1'b1,1'b1,8'h58,2'd0,12'd1000},  // R8 code5
    {1'b0,1'b0,1'b1,8'h14,2'd1,12'd122},   // R9 code1
    {1'b0,1'b1,1'b1,8'h22,2'd2,12'd150},   // R8 code2
    {1'b0,1'b0,1'b1,8'h48,2'd0,12'd522},   // R9 code4
    {1'b0,1'b1,1'b1,8'h64,2'd1,12'd1500},  // R8 code6
    {1'b0,1'b1,1'b1,8'h08,2'd1,12'd0},     // R2 bcast strobe, only mcast enabled
    {1'b0,1'b1,1'b1,8'h06,2'd0,12'd0},     // R2 mcast strobe, mcast disabled
    {1'b0,1'b1,1'b1,8'h01,2'd1,12'd0},     // R4 any set: type strobe ignored
    {1'b0,1'b1,1'b1,8'h01,2'd3,12'd50},    // R4 any set: preamble triggers
    {1'b0,1'b0,1'b1,8'h0E,2'd3,12'd0},     // R4 preamble without any bit
    {1'b0,1'b1,1'b0,8'h0F,2'd0,12'd0},     // R3 below threshold
    {1'b1,1'b1,1'b1,8'h08,2'd0,12'd0},     // R5 full duplex, type bit
    {1'b1,1'b1,1'b1,8'h01,2'd3,12'd0}      // R5 full duplex, any bit: no jam
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] fifo_level = 8'd0, fifo_thresh = 8'd100;
  logic       full_duplex = 1'b0, speed_100 = 1'b1;
  logic [7:0] ctrl = 8'h00;
  logic       frm_mcast = 1'b0, frm_bcast = 1'b0, frm_addr_hit = 1'b0, preamble_ok = 1'b0;
  logic       bp_req, pause_req;
  int         n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  rx_flow_trigger #(.CLK_MHZ(CLK_MHZ), .LVL_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .fifo_thresh(fifo_thresh),
    .full_duplex(full_duplex), .speed_100(speed_100), .ctrl(ctrl),
    .frm_mcast(frm_mcast), .frm_bcast(frm_bcast), .frm_addr_hit(frm_addr_hit),
    .preamble_ok(preamble_ok), .bp_req(bp_req), .pause_req(pause_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic strobe(input logic [1:0] kind);
    @(negedge clk);
    frm_mcast    = (kind == 2'd0);
    frm_bcast    = (kind == 2'd1);
    frm_addr_hit = (kind == 2'd2);
    preamble_ok  = (kind == 2'd3);
    @(negedge clk);
    {frm_mcast, frm_bcast, frm_addr_hit, preamble_ok} = 4'b0;
  endtask

  task automatic count_bp(output int n);
    n = 0;
    while (bp_req && n < 4000) begin
      n++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 bp during reset", bp_req, 0);
    chk("R1 pause during reset", pause_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bp after reset", bp_req, 0);
    chk("R1 pause after reset", pause_req, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      full_duplex = VEC[i][24];
      speed_100   = VEC[i][23];
      fifo_level  = VEC[i][22] ? 8'd200 : 8'd40;
      ctrl        = VEC[i][21:14];
      strobe(VEC[i][13:12]);
      count_bp(n);
      chk($sformatf("R2/R8 vector %0d length", i), n, int'(VEC[i][11:0]));
      repeat (2) @(negedge clk);
    end

    // R11: second trigger mid-hold does not extend
    full_duplex = 1'b0; speed_100 = 1'b1; fifo_level = 8'd200; ctrl = 8'h08;
    strobe(2'd0);
    repeat (10) @(negedge clk);
    frm_mcast = 1'b1;
    @(negedge clk);
    frm_mcast = 1'b0;
    count_bp(n);
    chk("R11 no restart total", n + 11, 50);

    // R12: entering full duplex drops bp at once
    ctrl = 8'h78;
    strobe(2'd0);
    repeat (5) @(negedge clk);
    chk("R12 bp active before switch", bp_req, 1);
    full_duplex = 1'b1;
    #1 chk("R12 bp drops on full duplex", bp_req, 0);
    @(negedge clk);
    full_duplex = 1'b0;
    @(negedge clk);
    chk("R12 remaining time discarded", bp_req, 0);

    // R12: clearing enables drops bp at once
    strobe(2'd0);
    repeat (3) @(negedge clk);
    ctrl = 8'h70;
    #1 chk("R12 bp drops on enables cleared", bp_req, 0);
    @(negedge clk);
    ctrl = 8'h78;
    @(negedge clk);
    chk("R12 stays low after re-enable", bp_req, 0);

    // R5: full duplex with only type bits: no pause
    @(negedge clk);
    fifo_level = 8'd40; ctrl = 8'h0E; full_duplex = 1'b1;
    @(negedge clk);
    fifo_level = 8'd200;
    repeat (3) begin
      @(negedge clk);
      chk("R5 no pause from type bits", pause_req, 0);
    end

    // R6 / R7: pause once per crossing
    ctrl = 8'h01;
    @(negedge clk);
    chk("R6 pause asserted", pause_req, 1);
    @(negedge clk);
    chk("R6 pause one cycle", pause_req, 0);
    repeat (4) begin
      @(negedge clk);
      chk("R7 no repeat while above", pause_req, 0);
    end
    fifo_level = 8'd99;
    @(negedge clk);
    chk("R3 no pause below threshold", pause_req, 0);
    fifo_level = 8'd100;
    @(negedge clk);
    chk("R7 re-armed pause", pause_req, 1);

    // R6: half duplex never pauses
    @(negedge clk);
    full_duplex = 1'b0; fifo_level = 8'd40;
    @(negedge clk);
    fifo_level = 8'd200;
    @(negedge clk);
    chk("R6 no pause in half duplex", pause_req, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule